// File: doc/BRIEF.md
# Registered Integer Execute Stage

This block is the integer execute stage of a 32-bit load/store core. Each cycle it may accept one operation: a 6-bit operation code, two source register indices with the values read for them, a 16-bit immediate, a 5-bit shift immediate and a destination index. One clock later it presents the result, the destination index and a write enable for the register file.

It covers addition and subtraction, the bitwise operations including nor, six compare-and-set conditions, shifts and rotates in register and immediate forms, and immediate logic that acts on the upper half of the word. The rules for extending the immediate depend on the operation. The register file, memory access, multiply and divide are handled by other stages.

Opcode encoding (decimal): 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 cmp-ge, 7 cmp-lt, 8 cmp-ne, 9 cmp-eq, 10 cmp-geu, 11 cmp-ltu, 12 sll, 13 srl, 14 sra, 15 rol, 16 ror, 17 slli, 18 srli, 19 srai, 20 roli, 21 addi, 22 andi, 23 ori, 24 xori, 25 andhi, 26 orhi, 27 xorhi, 28 cmp-gei, 29 cmp-lti, 30 cmp-nei, 31 cmp-eqi, 32 cmp-geui, 33 cmp-ltui. Codes 34 to 63 are undefined.

Top module: `int_exec_stage`

## Requirements
- R1: Opcode 0 returns rA+rB and opcode 1 returns rA-rB, both modulo 2^32. Opcode 21 returns rA plus imm16 sign-extended to 32 bits.
- R2: Opcodes 2, 3, 4 and 5 return rA&rB, rA|rB, rA^rB and ~(rA|rB).
- R3: Opcodes 22, 23 and 24 apply and, or and xor between rA and imm16 zero-extended, so bits 31:16 of the immediate operand are 0.
- R4: Opcodes 25, 26 and 27 apply and, or and xor between rA and the operand {imm16, 16'h0000}. The low half of rA is therefore cleared by andhi and passed unchanged by orhi and xorhi.
- R5: Register compares (opcodes 6 to 11) return 32'd1 when the condition holds and 32'd0 otherwise. The conditions are rA>=rB signed, rA<rB signed, rA!=rB, rA==rB, rA>=rB unsigned, and rA<rB unsigned.
- R6: Immediate compares (opcodes 28 to 33) compare rA with imm16 and return 1 or 0. The ge, lt, ne and eq forms sign-extend imm16. The geu and ltu forms zero-extend it.
- R7: Register shifts sll, srl and sra (12, 13, 14) use only rB[4:0] as the amount. sra fills from bit 31. An amount field of 32 therefore acts as a shift by zero.
- R8: Immediate shifts slli, srli, srai and roli (17 to 20) take the amount from imm5. rB has no effect on them.
- R9: rol (15) and ror (16) rotate rA left or right by rB[4:0]. Bits leaving one end enter at the other.
- R10: An operation whose destination index is 0 produces out_valid but keeps out_wr_en low.
- R11: A source whose index is 0 is taken as the value 0, whatever value is presented for it.
- R12: out_valid equals in_valid delayed by one clock. out_wr_en is never high while out_valid is low. out_wr_idx carries the destination index of the accepted operation.
- R13: While rst (synchronous, active high) is sampled high, the next edge clears out_valid, out_wr_en and out_result.
- R14: An undefined opcode (34 to 63) produces out_valid with out_wr_en low and out_result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 6 | Operation code |
| a_idx | input | 5 | Index of source A |
| a_val | input | 32 | Value read for source A |
| b_idx | input | 5 | Index of source B |
| b_val | input | 32 | Value read for source B |
| imm16 | input | 16 | 16-bit immediate |
| imm5 | input | 5 | Shift-amount immediate |
| dst_idx | input | 5 | Destination register index |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Result value |
| out_wr_en | output | 1 | Register file write enable |
| out_wr_idx | output | 5 | Register file write index |

## Verification
The bench targets the places where immediate extension differs by operation. An unsigned immediate compare with bit 15 set exposes a design that sign-extends it by flipping the answer. The same bit 15 in andi and ori exposes the same mistake through set upper bits. Register shift amounts of 35 and 32 reveal a design that does not mask rB, because such a design returns zero instead of a shift by 3 or 0. Arithmetic shifts of a negative value, rotates in both directions, a destination of 0 and a source index 0 carrying a nonzero value each make a wrong design show the wrong fill, a write to r0, or leaked data.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int XLEN    = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 16;
  localparam int OP_W    = 6;
  localparam int SHAMT_W = $clog2(XLEN);

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 6'd0,  OP_SUB   = 6'd1,  OP_AND   = 6'd2,  OP_OR    = 6'd3,
    OP_XOR   = 6'd4,  OP_NOR   = 6'd5,  OP_CGE   = 6'd6,  OP_CLT   = 6'd7,
    OP_CNE   = 6'd8,  OP_CEQ   = 6'd9,  OP_CGEU  = 6'd10, OP_CLTU  = 6'd11,
    OP_SLL   = 6'd12, OP_SRL   = 6'd13, OP_SRA   = 6'd14, OP_ROL   = 6'd15,
    OP_ROR   = 6'd16, OP_SLLI  = 6'd17, OP_SRLI  = 6'd18, OP_SRAI  = 6'd19,
    OP_ROLI  = 6'd20, OP_ADDI  = 6'd21, OP_ANDI  = 6'd22, OP_ORI   = 6'd23,
    OP_XORI  = 6'd24, OP_ANDHI = 6'd25, OP_ORHI  = 6'd26, OP_XORHI = 6'd27,
    OP_CGEI  = 6'd28, OP_CLTI  = 6'd29, OP_CNEI  = 6'd30, OP_CEQI  = 6'd31,
    OP_CGEUI = 6'd32, OP_CLTUI = 6'd33
  } exe_op_e;

  typedef enum logic [2:0] {
    SH_LL, SH_RL, SH_RA, SH_RL_ROT, SH_RR_ROT
  } shift_kind_e;

  typedef enum logic [2:0] {
    CC_GE, CC_LT, CC_NE, CC_EQ, CC_GEU, CC_LTU
  } cmp_cond_e;

  function automatic logic [XLEN-1:0] shift_word(shift_kind_e k,
                                                 logic [XLEN-1:0] v,
                                                 logic [SHAMT_W-1:0] s);
    logic [SHAMT_W:0] inv;
    inv = (SHAMT_W+1)'(XLEN) - {1'b0, s};
    case (k)
      SH_LL:     return v << s;
      SH_RL:     return v >> s;
      SH_RA:     return $unsigned($signed(v) >>> s);
      SH_RL_ROT: return (v << s) | (v >> inv);
      default:   return (v >> s) | (v << inv);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] cmp_word(cmp_cond_e c,
                                               logic [XLEN-1:0] x,
                                               logic [XLEN-1:0] y);
    logic hit;
    case (c)
      CC_GE:   hit = $signed(x) >= $signed(y);
      CC_LT:   hit = $signed(x) <  $signed(y);
      CC_NE:   hit = x != y;
      CC_EQ:   hit = x == y;
      CC_GEU:  hit = x >= y;
      default: hit = x <  y;
    endcase
    return {{(XLEN-1){1'b0}}, hit};
  endfunction
endpackage

// File: rtl/exe_operand_sel.sv
module exe_operand_sel
  import int_exec_pkg::*;
(
  input  exe_op_e              op_e,
  input  logic [IDX_W-1:0]     a_idx,
  input  logic [XLEN-1:0]      a_val,
  input  logic [IDX_W-1:0]     b_idx,
  input  logic [XLEN-1:0]      b_val,
  input  logic [IMM_W-1:0]     imm16,
  input  logic [SHAMT_W-1:0]   imm5,
  output logic [XLEN-1:0]      opa,
  output logic [XLEN-1:0]      opb,
  output logic [SHAMT_W-1:0]   shamt
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] src_a, src_b;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_hi;

  // index 0 is hard-wired zero (R11)
  assign src_a  = (a_idx == '0) ? '0 : a_val;
  assign src_b  = (b_idx == '0) ? '0 : b_val;

  assign imm_sx = {{PAD_W{imm16[IMM_W-1]}}, imm16};
  assign imm_zx = {{PAD_W{1'b0}}, imm16};
  assign imm_hi = {imm16, {PAD_W{1'b0}}};

  assign opa = src_a;

  always_comb begin
    case (op_e)
      OP_ADDI, OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI: opb = imm_sx;
      OP_ANDI, OP_ORI, OP_XORI, OP_CGEUI, OP_CLTUI: opb = imm_zx;
      OP_ANDHI, OP_ORHI, OP_XORHI:                 opb = imm_hi;
      default:                                     opb = src_b;
    endcase
  end

  always_comb begin
    case (op_e)
      OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI: shamt = imm5;
      default:                            shamt = src_b[SHAMT_W-1:0];
    endcase
  end
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import int_exec_pkg::*;
(
  input  exe_op_e             op_e,
  input  logic [XLEN-1:0]     opa,
  input  logic [XLEN-1:0]     opb,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [XLEN-1:0]     res,
  output logic                legal,
  output logic                is_cmp
);
  always_comb begin
    legal  = 1'b1;
    is_cmp = 1'b0;
    res    = '0;
    case (op_e)
      OP_ADD, OP_ADDI:             res = opa + opb;
      OP_SUB:                      res = opa - opb;
      OP_AND, OP_ANDI, OP_ANDHI:   res = opa & opb;
      OP_OR,  OP_ORI,  OP_ORHI:    res = opa | opb;
      OP_XOR, OP_XORI, OP_XORHI:   res = opa ^ opb;
      OP_NOR:                      res = ~(opa | opb);
      OP_SLL, OP_SLLI:             res = shift_word(SH_LL, opa, shamt);
      OP_SRL, OP_SRLI:             res = shift_word(SH_RL, opa, shamt);
      OP_SRA, OP_SRAI:             res = shift_word(SH_RA, opa, shamt);
      OP_ROL, OP_ROLI:             res = shift_word(SH_RL_ROT, opa, shamt);
      OP_ROR:                      res = shift_word(SH_RR_ROT, opa, shamt);
      OP_CGE,  OP_CGEI:  begin is_cmp = 1'b1; res = cmp_word(CC_GE,  opa, opb); end
      OP_CLT,  OP_CLTI:  begin is_cmp = 1'b1; res = cmp_word(CC_LT,  opa, opb); end
      OP_CNE,  OP_CNEI:  begin is_cmp = 1'b1; res = cmp_word(CC_NE,  opa, opb); end
      OP_CEQ,  OP_CEQI:  begin is_cmp = 1'b1; res = cmp_word(CC_EQ,  opa, opb); end
      OP_CGEU, OP_CGEUI: begin is_cmp = 1'b1; res = cmp_word(CC_GEU, opa, opb); end
      OP_CLTU, OP_CLTUI: begin is_cmp = 1'b1; res = cmp_word(CC_LTU, opa, opb); end
      default:                     legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
  import int_exec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      op,
  input  logic [IDX_W-1:0]     a_idx,
  input  logic [XLEN-1:0]      a_val,
  input  logic [IDX_W-1:0]     b_idx,
  input  logic [XLEN-1:0]      b_val,
  input  logic [IMM_W-1:0]     imm16,
  input  logic [SHAMT_W-1:0]   imm5,
  input  logic [IDX_W-1:0]     dst_idx,
  output logic                 out_valid,
  output logic [XLEN-1:0]      out_result,
  output logic                 out_wr_en,
  output logic [IDX_W-1:0]     out_wr_idx
);
  exe_op_e             op_e;
  logic [XLEN-1:0]     opa, opb, alu_res;
  logic [SHAMT_W-1:0]  shamt;
  logic                alu_legal, alu_cmp;
  logic                dst_live;
  logic                cmp_q, illegal_q;

  assign op_e     = exe_op_e'(op);
  assign dst_live = (dst_idx != '0);

  exe_operand_sel u_sel (
    .op_e  (op_e),
    .a_idx (a_idx),
    .a_val (a_val),
    .b_idx (b_idx),
    .b_val (b_val),
    .imm16 (imm16),
    .imm5  (imm5),
    .opa   (opa),
    .opb   (opb),
    .shamt (shamt)
  );

  exe_alu u_alu (
    .op_e   (op_e),
    .opa    (opa),
    .opb    (opb),
    .shamt  (shamt),
    .res    (alu_res),
    .legal  (alu_legal),
    .is_cmp (alu_cmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_result <= '0;
      out_wr_idx <= '0;
      cmp_q      <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid & alu_legal & dst_live;
      if (in_valid) begin
        out_result <= alu_legal ? alu_res : '0;
        out_wr_idx <= dst_idx;
        cmp_q      <= alu_cmp;
        illegal_q  <= ~alu_legal;
      end
    end
  end

  assert_no_r0_write_R10: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> (out_wr_idx != '0));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_wr_needs_valid_R12: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> out_valid);

  assert_cmp_is_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cmp_q) |-> (out_result[XLEN-1:1] == '0));

  assert_undef_silent_R14: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal_q) |-> (!out_wr_en && out_result == '0));

  assert_reset_clears_R13: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_wr_en && out_result == '0));
endmodule

// File: tb/tb_int_exec_stage.sv
module tb_int_exec_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  op = '0;
  logic [4:0]  a_idx = '0, b_idx = '0, dst_idx = '0, imm5 = '0;
  logic [31:0] a_val = '0, b_val = '0;
  logic [15:0] imm16 = '0;
  logic        out_valid, out_wr_en;
  logic [31:0] out_result;
  logic [4:0]  out_wr_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  int_exec_stage dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .a_idx(a_idx), .a_val(a_val), .b_idx(b_idx), .b_val(b_val),
    .imm16(imm16), .imm5(imm5), .dst_idx(dst_idx),
    .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // issue one op with full control over indices, sample after the edge
  task automatic issue(input logic [5:0] o, input logic [4:0] ai, input logic [31:0] av,
                       input logic [4:0] bi, input logic [31:0] bv,
                       input logic [15:0] i16, input logic [4:0] i5,
                       input logic [4:0] d);
    @(negedge clk);
    op = o; a_idx = ai; a_val = av; b_idx = bi; b_val = bv;
    imm16 = i16; imm5 = i5; dst_idx = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [5:0] o,
                     input logic [31:0] av, input logic [31:0] bv,
                     input logic [15:0] i16, input logic [4:0] i5,
                     input logic [31:0] exp);
    issue(o, 5'd3, av, 5'd4, bv, i16, i5, 5'd9);
    chk(out_result === exp, tag, out_result, exp);
    chk(out_valid === 1'b1 && out_wr_en === 1'b1 && out_wr_idx === 5'd9,
        {tag, " write strobe"}, {26'd0, out_valid, out_wr_en, out_wr_idx}, 32'h69);
  endtask

  task automatic t_reset_R13();
    chk(out_valid === 1'b0 && out_wr_en === 1'b0 && out_result === 32'd0,
        "R13 reset state", out_result, 32'd0);
  endtask

  task automatic t_arith_R1();
    run("R1 add", 6'd0, 32'd5, 32'd7, 16'h0, 5'd0, 32'd12);
    run("R1 sub", 6'd1, 32'd3, 32'd5, 16'h0, 5'd0, 32'hFFFF_FFFE);
    run("R1 addi sext", 6'd21, 32'd10, 32'd0, 16'hFFFF, 5'd0, 32'd9);
  endtask

  task automatic t_logic_R2();
    run("R2 and", 6'd2, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'h00F0_000F);
    run("R2 or",  6'd3, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'hFFF0_0FFF);
    run("R2 xor", 6'd4, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'hFF00_0FF0);
    run("R2 nor", 6'd5, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0, 5'd0, 32'h000F_F000);
  endtask

  task automatic t_logic_imm_R3();
    run("R3 andi zext", 6'd22, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, 32'h0000_8001);
    run("R3 ori zext",  6'd23, 32'h1234_0000, 32'h0, 16'h8000, 5'd0, 32'h1234_8000);
    run("R3 xori",      6'd24, 32'hFFFF_FFFF, 32'h0, 16'h00FF, 5'd0, 32'hFFFF_FF00);
  endtask

  task automatic t_high_R4();
    run("R4 andhi", 6'd25, 32'hFFFF_FFFF, 32'h0, 16'h1234, 5'd0, 32'h1234_0000);
    run("R4 orhi",  6'd26, 32'h0000_5678, 32'h0, 16'hABCD, 5'd0, 32'hABCD_5678);
    run("R4 xorhi", 6'd27, 32'hFFFF_0001, 32'h0, 16'h00FF, 5'd0, 32'hFF00_0001);
  endtask

  task automatic t_cmp_R5();
    run("R5 cmplt signed",    6'd7,  32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd1);
    run("R5 cmpltu",          6'd11, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd0);
    run("R5 cmpge signed",    6'd6,  32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd0);
    run("R5 cmpgeu",          6'd10, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd1);
    run("R5 cmpeq",           6'd9,  32'd7, 32'd7, 16'h0, 5'd0, 32'd1);
    run("R5 cmpne",           6'd8,  32'd7, 32'd7, 16'h0, 5'd0, 32'd0);
  endtask

  task automatic t_cmp_imm_R6();
    run("R6 cmplti sext",  6'd29, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0, 32'd1);
    run("R6 cmpltui zext", 6'd33, 32'h0000_9000, 32'h0, 16'h8000, 5'd0, 32'd0);
    run("R6 cmpgeui zext", 6'd32, 32'h0001_0000, 32'h0, 16'hFFFF, 5'd0, 32'd1);
    run("R6 cmpeqi sext",  6'd31, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'd1);
    run("R6 cmpnei sext",  6'd30, 32'h0000_FFFF, 32'h0, 16'hFFFF, 5'd0, 32'd1);
    run("R6 cmpgei neg",   6'd28, 32'h0,         32'h0, 16'h8000, 5'd0, 32'd1);
  endtask

  task automatic t_shift_reg_R7();
    run("R7 sll amt 35->3",  6'd12, 32'd1, 32'd35, 16'h0, 5'd0, 32'd8);
    run("R7 srl masked",     6'd13, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0, 5'd0, 32'h0800_0000);
    run("R7 sra fill",       6'd14, 32'h8000_0000, 32'd4, 16'h0, 5'd0, 32'hF800_0000);
    run("R7 sll amt 32->0",  6'd12, 32'h1234_5678, 32'd32, 16'h0, 5'd0, 32'h1234_5678);
  endtask

  task automatic t_shift_imm_R8();
    run("R8 slli",  6'd17, 32'h3, 32'd1, 16'h0, 5'd30, 32'hC000_0000);
    run("R8 srli",  6'd18, 32'hF000_0000, 32'd1, 16'h0, 5'd28, 32'h0000_000F);
    run("R8 srai",  6'd19, 32'h8000_0000, 32'd1, 16'h0, 5'd31, 32'hFFFF_FFFF);
  endtask

  task automatic t_rotate_R9();
    run("R9 rol",  6'd15, 32'h8000_0001, 32'd1, 16'h0, 5'd0, 32'h0000_0003);
    run("R9 ror",  6'd16, 32'h8000_0001, 32'd1, 16'h0, 5'd0, 32'hC000_0000);
    run("R9 roli", 6'd20, 32'h1234_5678, 32'd3, 16'h0, 5'd8, 32'h3456_7812);
    run("R9 ror 33->1", 6'd16, 32'h0000_0002, 32'd33, 16'h0, 5'd0, 32'h0000_0001);
  endtask

  task automatic t_dst_zero_R10();
    issue(6'd0, 5'd3, 32'd1, 5'd4, 32'd2, 16'h0, 5'd0, 5'd0);
    chk(out_valid === 1'b1 && out_wr_en === 1'b0, "R10 dst r0 suppressed",
        {30'd0, out_valid, out_wr_en}, 32'h2);
  endtask

  task automatic t_src_zero_R11();
    issue(6'd0, 5'd0, 32'h0000_DEAD, 5'd4, 32'd5, 16'h0, 5'd0, 5'd6);
    chk(out_result === 32'd5, "R11 rA index 0 reads zero", out_result, 32'd5);
    issue(6'd1, 5'd3, 32'd10, 5'd0, 32'd99, 16'h0, 5'd0, 5'd6);
    chk(out_result === 32'd10, "R11 rB index 0 reads zero", out_result, 32'd10);
  endtask

  task automatic t_handshake_R12();
    issue(6'd0, 5'd3, 32'd1, 5'd4, 32'd1, 16'h0, 5'd0, 5'd17);
    chk(out_wr_idx === 5'd17, "R12 write index", {27'd0, out_wr_idx}, 32'd17);
    @(negedge clk);
    chk(out_valid === 1'b0 && out_wr_en === 1'b0, "R12 idle cycle",
        {30'd0, out_valid, out_wr_en}, 32'd0);
  endtask

  task automatic t_undefined_R14();
    issue(6'd63, 5'd3, 32'hFFFF_FFFF, 5'd4, 32'd1, 16'h0, 5'd0, 5'd9);
    chk(out_valid === 1'b1 && out_wr_en === 1'b0 && out_result === 32'd0,
        "R14 undefined opcode", out_result, 32'd0);
    issue(6'd34, 5'd3, 32'd7, 5'd4, 32'd7, 16'h0, 5'd0, 5'd9);
    chk(out_wr_en === 1'b0 && out_result === 32'd0, "R14 first undefined code",
        out_result, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R13();
    rst = 1'b0;
    t_arith_R1();
    t_logic_R2();
    t_logic_imm_R3();
    t_high_R4();
    t_cmp_R5();
    t_cmp_imm_R6();
    t_shift_reg_R7();
    t_shift_imm_R8();
    t_rotate_R9();
    t_dst_zero_R10();
    t_src_zero_R11();
    t_handshake_R12();
    t_undefined_R14();
    // reset in mid-stream clears the stage (R13)
    @(negedge clk);
    op = 6'd0; a_idx = 5'd3; a_val = 32'd4; b_idx = 5'd4; b_val = 32'd4;
    dst_idx = 5'd2; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    t_reset_R13();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule